// File: doc/BRIEF.md
# Chained Compare Unit with Selectable Boolean Encoding

The block takes two 32-bit operands and decides a relation between them. The operands are read as unsigned integers, signed integers or single-precision floating-point values. The decided condition is then merged with a third chain operand by a logical OR or a logical AND, and the merged truth value comes out as a 32-bit word in one of four selectable encodings. Chaining lets several conditions be folded together without separate bitwise steps. Tying the chain operand to zero in OR mode gives the plain comparison.

A sequence mode splits a 64-bit compare into two requests. The first request compares the low words unsigned and returns the low-half encoding. The second request compares the high words, unsigned or signed, and receives the first result as its chain operand. When the high words are equal, the second request passes the low-half verdict through. Otherwise it decides on the high words alone. Each request enters through a valid/ready handshake, and the result is held in a register until the consumer takes it.

Top module: `cmpu_top`

## Requirements
- R1: A request is accepted on a clock edge where `in_valid` and `in_ready` are both high, and its result appears on `out_result` with `out_valid` high after that edge. While `out_ready` is low, `out_valid` stays high and `out_result` stays unchanged. `in_ready` is high whenever no result is pending or the pending result is being taken.
- R2: For integer operands (`op_type` 0 = unsigned, 1 = signed), the `cond` codes decide as follows: 0 equal, 1 greater, 2 greater-or-equal, 3 not-equal, 4 less, 5 less-or-equal, 6 greater-or-less (the same as not-equal for integers). Every relation uses A on the left and B on the right.
- R3: For floating-point operands (`op_type` 2), the comparison follows IEEE 754, and -0.0 equals +0.0. If either operand is a NaN, codes 0, 1, 2, 4, 5 and 6 are false and code 3 is true.
- R4: Code 7 is true when A comes strictly before B in a total order. In that order -0.0 comes before +0.0, and every NaN comes after +infinity. For integer operands, code 7 acts as code 4.
- R5: `res_type` selects the output word. 0 gives 0 or 1. 1 gives 0x00000000 or 0x3F800000. 2 gives 0 or 0xFFFFFFFF. 3 is the low-half form and gives 0 or 1 in bit 0.
- R6: When `seq_mode` is 0, the condition is ORed with (C != 0) if `and_mode` is 0, and ANDed with (C != 0) if `and_mode` is 1. The merged value is encoded per R5.
- R7: When `seq_mode` is 1 and A equals B, the outcome is (C != 0). Otherwise the outcome is false for code 0, true for codes 3 and 6, A<B for codes 4, 5 and 7, and A>B for codes 1 and 2. A low-half request followed by such a high-half request gives the correct 64-bit result.
- R8: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| a | input | 32 | Left operand |
| b | input | 32 | Right operand |
| c | input | 32 | Chain operand, true when nonzero |
| cond | input | 3 | Condition code |
| op_type | input | 2 | Operand interpretation |
| res_type | input | 2 | Output encoding |
| and_mode | input | 1 | 1 = AND with chain, 0 = OR |
| seq_mode | input | 1 | High-half stage of a 64-bit compare |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_result | output | 32 | Encoded boolean |

## Verification
The bench targets the floating-point corners where integer-style logic goes wrong. These are signed zeros, which a bitwise compare would call unequal, and NaN operands, where a design that skipped the unordered check would report less or greater, or return false for not-equal. Total order is tested at -0.0 versus +0.0 and at +infinity versus NaN, where a plain IEEE compare gives false both ways. The 64-bit sequences use high words that are equal and unequal, in both the signed and unsigned forms. A design that ignored the chain operand would fail the equal case, and one that kept chaining in sequence mode would fail the other. The consumer stalls at irregular points, so a result that changes or disappears while it waits is caught.

// File: rtl/cmpu_pkg.sv
package cmpu_pkg;
  typedef enum logic [2:0] {
    CC_EQ, CC_GT, CC_GE, CC_NE, CC_LT, CC_LE, CC_GTLT, CC_TOTAL
  } cond_e;

  typedef enum logic [1:0] {OT_UINT, OT_SINT, OT_FP32, OT_RSVD} optype_e;

  typedef enum logic [1:0] {RT_I1, RT_F1, RT_M1, RT_U1} restype_e;

  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
    logic unord;
  } rel_t;
endpackage

// File: rtl/cmpu_relate.sv
module cmpu_relate
  import cmpu_pkg::*;
#(
  parameter int W     = 32,
  parameter int EXP_W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  optype_e      ot,
  output rel_t         rel,
  output rel_t         trel
);
  localparam int MAG_W = W - 1;
  localparam int MAN_W = MAG_W - EXP_W;

  function automatic logic is_nan(input logic [W-1:0] x);
    return (&x[MAG_W-1 -: EXP_W]) && (|x[MAN_W-1:0]);
  endfunction

  // Order key: NaNs above everything, negatives flipped, -0 below +0.
  function automatic logic [W:0] order_key(input logic [W-1:0] x);
    if (is_nan(x)) return {1'b1, 1'b0, x[MAG_W-1:0]};
    if (x[W-1])    return {1'b0, ~x};
    return {1'b0, 1'b1, x[MAG_W-1:0]};
  endfunction

  logic a_nan, b_nan, mag_lt, mag_eq, both_zero;

  always_comb begin
    a_nan     = is_nan(a);
    b_nan     = is_nan(b);
    mag_lt    = a[MAG_W-1:0] < b[MAG_W-1:0];
    mag_eq    = a[MAG_W-1:0] == b[MAG_W-1:0];
    both_zero = (a[MAG_W-1:0] == '0) && (b[MAG_W-1:0] == '0);
    rel       = '0;
    trel      = '0;
    case (ot)
      OT_SINT: begin
        rel.lt = $signed(a) < $signed(b);
        rel.eq = a == b;
        rel.gt = $signed(a) > $signed(b);
      end
      OT_FP32: begin
        if (both_zero) begin
          rel.eq = 1'b1;
        end else if (a[W-1] != b[W-1]) begin
          rel.lt = a[W-1];
          rel.gt = b[W-1];
        end else if (!a[W-1]) begin
          rel.lt = mag_lt;
          rel.eq = mag_eq;
          rel.gt = !mag_lt && !mag_eq;
        end else begin
          rel.lt = !mag_lt && !mag_eq;
          rel.eq = mag_eq;
          rel.gt = mag_lt;
        end
        if (a_nan || b_nan) begin
          rel = '0;
          rel.unord = 1'b1;
        end
      end
      default: begin
        rel.lt = a < b;
        rel.eq = a == b;
        rel.gt = a > b;
      end
    endcase
    if (ot == OT_FP32) begin
      trel.lt = order_key(a) < order_key(b);
      trel.eq = order_key(a) == order_key(b);
      trel.gt = order_key(a) > order_key(b);
    end else begin
      trel = rel;
    end
  end
endmodule

// File: rtl/cmpu_decide.sv
module cmpu_decide
  import cmpu_pkg::*;
(
  input  cond_e cc,
  input  rel_t  rel,
  input  rel_t  trel,
  input  logic  c_true,
  input  logic  and_mode,
  input  logic  seq_mode,
  output logic  cond_hit,
  output logic  outcome
);
  logic strict_hit;

  always_comb begin
    case (cc)
      CC_EQ:   cond_hit = rel.eq;
      CC_GT:   cond_hit = rel.gt;
      CC_GE:   cond_hit = rel.gt | rel.eq;
      CC_NE:   cond_hit = rel.unord | !rel.eq;
      CC_LT:   cond_hit = rel.lt;
      CC_LE:   cond_hit = rel.lt | rel.eq;
      CC_GTLT: cond_hit = !rel.unord & !rel.eq;
      default: cond_hit = trel.lt;
    endcase
    case (cc)
      CC_EQ:                strict_hit = 1'b0;
      CC_NE, CC_GTLT:       strict_hit = 1'b1;
      CC_GT, CC_GE:         strict_hit = rel.gt;
      default:              strict_hit = rel.lt;
    endcase
    if (seq_mode)      outcome = rel.eq ? c_true : strict_hit;
    else if (and_mode) outcome = cond_hit & c_true;
    else               outcome = cond_hit | c_true;
  end
endmodule

// File: rtl/cmpu_top.sv
module cmpu_top
  import cmpu_pkg::*;
#(
  parameter int W     = 32,
  parameter int EXP_W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  logic [2:0]   cond,
  input  logic [1:0]   op_type,
  input  logic [1:0]   res_type,
  input  logic         and_mode,
  input  logic         seq_mode,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [W-1:0] FP_ONE = W'(BIAS) << (W - 1 - EXP_W);

  function automatic logic [W-1:0] encode(input restype_e rt, input logic v);
    case (rt)
      RT_F1:   return v ? FP_ONE : '0;
      RT_M1:   return {W{v}};
      default: return {{(W-1){1'b0}}, v};
    endcase
  endfunction

  rel_t rel, trel;
  logic ev_hit, ev_outcome, ev_fire, ev_unord, ev_fp;
  logic [2:0] ev_cond;

  cmpu_relate #(.W(W), .EXP_W(EXP_W)) u_relate (
    .a(a), .b(b), .ot(optype_e'(op_type)), .rel(rel), .trel(trel)
  );

  cmpu_decide u_decide (
    .cc(cond_e'(cond)), .rel(rel), .trel(trel), .c_true(|c),
    .and_mode(and_mode), .seq_mode(seq_mode),
    .cond_hit(ev_hit), .outcome(ev_outcome)
  );

  assign in_ready = !out_valid || out_ready;
  assign ev_fire  = in_valid && in_ready;
  assign ev_unord = rel.unord;
  assign ev_fp    = optype_e'(op_type) == OT_FP32;
  assign ev_cond  = cond;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else if (ev_fire) begin
      out_valid  <= 1'b1;
      out_result <= encode(restype_e'(res_type), ev_outcome);
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/cmpu_checker.sv
module cmpu_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ev_fire,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_result,
  input logic         ev_fp,
  input logic         ev_unord,
  input logic         ev_hit,
  input logic [2:0]   ev_cond
);
  localparam logic [W-1:0] ONE_W  = W'(1);
  localparam logic [W-1:0] FONE_W = W'(32'h3F80_0000);

  AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fire |=> out_valid); // R1
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result)); // R1
  AST_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !ev_fire |=> !out_valid); // R1
  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_result == '0 || out_result == ONE_W ||
                   out_result == FONE_W || out_result == '1)); // R5
  AST_NAN_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fp && ev_unord && ev_cond != 3'd3 && ev_cond != 3'd7 |-> !ev_hit); // R3
  AST_NAN_NE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fp && ev_unord && ev_cond == 3'd3 |-> ev_hit); // R3
endmodule

bind cmpu_top cmpu_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_fire(ev_fire), .out_valid(out_valid),
  .out_ready(out_ready), .out_result(out_result), .ev_fp(ev_fp),
  .ev_unord(ev_unord), .ev_hit(ev_hit), .ev_cond(ev_cond)
);

// File: tb/tb_cmpu_top.sv
module tb_cmpu_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [31:0] a = '0, b = '0, c = '0;
  logic [2:0] cond = '0;
  logic [1:0] op_type = '0, res_type = '0;
  logic and_mode = 1'b0, seq_mode = 1'b0;
  logic out_valid, out_ready = 1'b1;
  logic [31:0] out_result;

  int n_checks = 0, n_fail = 0, n_done = 0, n_sent = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic stall_en = 1'b0;

  always #10 clk = ~clk;

  cmpu_top dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, expv);
    end
  endtask

  // Reference model, written as value arithmetic rather than bit logic.
  function automatic bit fnan(input logic [31:0] x);
    return x[30:23] == 8'hFF && x[22:0] != 0;
  endfunction
  function automatic longint fval(input logic [31:0] x); // doubled, -0 -> -1
    longint m = longint'(x[30:0]) * 2;
    if (x[31]) return (m == 0) ? -1 : -m;
    return m;
  endfunction
  function automatic logic [31:0] enc(input int rt, input bit v);
    case (rt)
      0: return v ? 32'd1 : 32'd0;
      1: return v ? 32'h3F80_0000 : 32'd0;
      2: return v ? 32'hFFFF_FFFF : 32'd0;
      default: return v ? 32'd1 : 32'd0;
    endcase
  endfunction
  function automatic bit relate(input logic [31:0] x, input logic [31:0] y,
                                input int cc, input int ot);
    longint vx, vy;
    bit un = 0;
    if (ot == 2) begin
      if (cc == 7) begin
        if (fnan(x) && fnan(y)) return x[30:0] < y[30:0];
        if (fnan(x)) return 0;
        if (fnan(y)) return 1;
        return fval(x) < fval(y);
      end
      un = fnan(x) || fnan(y);
      vx = fval(x); vy = fval(y);
      if (vx == -1) vx = 0;
      if (vy == -1) vy = 0;
    end else if (ot == 1) begin
      vx = longint'($signed(x)); vy = longint'($signed(y));
    end else begin
      vx = longint'(x); vy = longint'(y);
    end
    if (un) return cc == 3;
    case (cc)
      0: return vx == vy;
      1: return vx > vy;
      2: return vx >= vy;
      3, 6: return vx != vy;
      4, 7: return vx < vy;
      default: return vx <= vy;
    endcase
  endfunction

  task automatic send(input logic [31:0] ia, input logic [31:0] ib, input logic [31:0] ic,
                      input int cc, input int ot, input int rt, input bit am, input bit sq,
                      input logic [31:0] expv, input string tag);
    bit acc;
    a = ia; b = ib; c = ic; cond = 3'(cc); op_type = 2'(ot); res_type = 2'(rt);
    and_mode = am; seq_mode = sq; in_valid = 1'b1;
    do begin
      @(negedge clk); acc = in_ready;
      @(posedge clk); #2;
    end while (!acc);
    in_valid = 1'b0;
    exp_q.push_back(expv);
    tag_q.push_back(tag);
    n_sent++;
  endtask

  task automatic plain(input logic [31:0] ia, input logic [31:0] ib, input logic [31:0] ic,
                       input int cc, input int ot, input int rt, input bit am, input string tag);
    bit hit = relate(ia, ib, cc, ot);
    bit v = am ? (hit && ic != 0) : (hit || ic != 0);
    send(ia, ib, ic, cc, ot, rt, am, 1'b0, enc(rt, v), tag);
  endtask

  task automatic wide(input logic [63:0] x, input logic [63:0] y, input int cc,
                      input bit sgn, input string tag);
    bit lo, full;
    longint sx = x, sy = y;
    lo = relate(x[31:0], y[31:0], cc, 0);
    case (cc)
      0: full = x == y;
      1: full = sgn ? sx > sy : x > y;
      2: full = sgn ? sx >= sy : x >= y;
      3: full = x != y;
      4: full = sgn ? sx < sy : x < y;
      default: full = sgn ? sx <= sy : x <= y;
    endcase
    send(x[31:0], y[31:0], 32'd0, cc, 0, 3, 1'b0, 1'b0, enc(3, lo), "R5 u1 low half");
    send(x[63:32], y[63:32], enc(3, lo), cc, sgn ? 1 : 0, 2, 1'b0, 1'b1, enc(2, full), tag);
  endtask

  // Consumer: irregular stalls once enabled.
  int cyc = 0;
  always @(posedge clk) begin
    #2;
    cyc++;
    out_ready = !stall_en || (cyc % 3 != 0 && cyc % 7 != 0);
  end

  // Monitor: scoreboard pop, plus hold check while stalled.
  logic held_v = 1'b0;
  logic [31:0] held_r;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held_v) begin
        check("R1 hold valid", {31'd0, out_valid}, 32'd1);
        check("R1 hold data", out_result, held_r);
      end
      held_v = out_valid && !out_ready;
      held_r = out_result;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check("R1 unexpected result", out_result, 32'hXXXX_XXXX);
        end else begin
          check(tag_q.pop_front(), out_result, exp_q.pop_front());
        end
        n_done++;
      end
    end
  end

  localparam logic [31:0] F1P = 32'h3F80_0000, F2P = 32'h4000_0000;
  localparam logic [31:0] FM1 = 32'hBF80_0000, FM2 = 32'hC000_0000;
  localparam logic [31:0] PZ = 32'h0, NZ = 32'h8000_0000;
  localparam logic [31:0] PINF = 32'h7F80_0000, QNAN = 32'h7FC0_0000, NNAN = 32'hFFC0_0001;

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R8 out_valid after reset", {31'd0, out_valid}, 32'd0);
    check("R8 in_ready after reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(posedge clk); #2;
    // R2 integer
    plain(32'd1, 32'hFFFF_FFFF, 0, 4, 0, 0, 0, "R2 uint lt");
    plain(32'd1, 32'hFFFF_FFFF, 0, 4, 1, 0, 0, "R2 sint lt");
    plain(32'd5, 32'hFFFF_FFFD, 0, 1, 1, 2, 0, "R2 sint gt m1");
    plain(32'd9, 32'd9, 0, 0, 0, 1, 0, "R2 eq f1");
    plain(32'd9, 32'd9, 0, 2, 1, 0, 0, "R2 ge equal");
    plain(32'd8, 32'd9, 0, 5, 0, 0, 0, "R2 le");
    plain(32'd8, 32'd9, 0, 3, 0, 2, 0, "R2 ne");
    plain(32'd9, 32'd9, 0, 6, 1, 0, 0, "R2 gtlt equal");
    stall_en = 1'b1;
    // R3 floating point
    plain(F1P, F2P, 0, 4, 2, 0, 0, "R3 1.0 lt 2.0");
    plain(FM2, FM1, 0, 4, 2, 0, 0, "R3 -2 lt -1");
    plain(FM1, FM2, 0, 1, 2, 2, 0, "R3 -1 gt -2");
    plain(NZ, PZ, 0, 0, 2, 1, 0, "R3 -0 eq +0");
    plain(NZ, PZ, 0, 4, 2, 0, 0, "R3 -0 not lt +0");
    plain(QNAN, F1P, 0, 3, 2, 0, 0, "R3 nan ne");
    plain(QNAN, F1P, 0, 6, 2, 0, 0, "R3 nan gtlt");
    plain(F1P, NNAN, 0, 0, 2, 2, 0, "R3 nan eq");
    plain(QNAN, QNAN, 0, 5, 2, 0, 0, "R3 nan le");
    plain(F1P, F2P, 0, 6, 2, 0, 0, "R3 gtlt ordered");
    // R4 total order
    plain(NZ, PZ, 0, 7, 2, 0, 0, "R4 -0 before +0");
    plain(PINF, QNAN, 0, 7, 2, 0, 0, "R4 inf before nan");
    plain(NNAN, PINF, 0, 7, 2, 0, 0, "R4 nan after inf");
    plain(FM1, F1P, 0, 7, 2, 2, 0, "R4 -1 before 1");
    plain(32'd3, 32'hFFFF_FFFF, 0, 7, 1, 0, 0, "R4 int total as lt");
    // R5 encodings
    plain(32'd1, 32'd1, 0, 0, 0, 3, 0, "R5 u1 true");
    plain(32'd1, 32'd2, 0, 0, 0, 1, 0, "R5 f1 false");
    // R6 chaining
    plain(32'd1, 32'd2, 32'd5, 0, 0, 0, 0, "R6 or with nonzero C");
    plain(32'd1, 32'd1, 32'd0, 0, 0, 2, 1, "R6 and with zero C");
    plain(32'd1, 32'd1, 32'h8000_0000, 0, 0, 1, 1, "R6 and with nonzero C");
    plain(32'd1, 32'd2, 32'd7, 0, 0, 0, 1, "R6 and false cond");
    // R7 sequence
    wide(64'h0000_0005_0000_0001, 64'h0000_0005_0000_0002, 4, 0, "R7 u64 lt hi equal");
    wide(64'h0000_0004_FFFF_FFFF, 64'h0000_0005_0000_0000, 4, 0, "R7 u64 lt hi differ");
    wide(64'hFFFF_FFFF_0000_0000, 64'h0000_0001_0000_0000, 4, 1, "R7 s64 lt negative");
    wide(64'hFFFF_FFFF_0000_0000, 64'h0000_0001_0000_0000, 4, 0, "R7 u64 gt unsigned");
    wide(64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 0, 0, "R7 u64 eq");
    wide(64'h1234_5678_9ABC_DEF0, 64'h1234_5679_9ABC_DEF0, 0, 0, "R7 u64 eq hi differ");
    wide(64'h1234_5678_0000_0001, 64'h1234_5678_0000_0000, 3, 0, "R7 u64 ne lo differ");
    wide(64'h8000_0000_0000_0003, 64'h8000_0000_0000_0003, 5, 1, "R7 s64 le equal");
    wide(64'h7000_0000_0000_0000, 64'h8000_0000_0000_0000, 2, 1, "R7 s64 ge");
    // back-to-back with no stall
    stall_en = 1'b0;
    for (int i = 0; i < 4; i++)
      plain(32'(i), 32'd2, 0, 5, 0, 0, 0, "R1 back to back");
    while (n_done < n_sent) @(posedge clk);
    #2;
    check("R1 queue drained", 32'(exp_q.size()), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL R1 watchdog: got %0d results expected %0d", n_done, n_sent);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule